// File: doc/BRIEF.md
# Variable-Length Serial Data Path

This block is the shifting core of a synchronous serial port that works either as the clock-driving master or as a slave clocked by an outside master. Software writes characters to a data port and reads received characters from the same address. A mode input sets the character length to anywhere from one bit up to the full byte. Outgoing characters are placed in the high end of the byte. Incoming characters land in the low end.

A single holding register with an empty flag sits between the bus and the shift register. In master mode, an accepted write starts a transfer. The block produces its own serial clock at one quarter of the system clock rate. In slave mode, a write only preloads the shift register, which then waits for edges from the outside master. A two-bit command register holds the level of the chip-select output and an end-of-frame marker. Both the bus and a DMA-style write strobe can load it. When a master character finishes with the marker set, the select line is released automatically.

Top module: `spi_datapath`

## Requirements
- R1: After reset: `tx_empty_o`=1, `rx_full_o`=0, `rd_data_o`=0, `ssv_o`=1, `eof_o`=0, `sck_o`=0.
- R2: A data write is accepted only while `tx_empty_o`=1, and an accepted write drives `tx_empty_o` low on the next cycle. A write made while `tx_empty_o`=0 is dropped and never reaches `sdo_o`.
- R3: In master mode, an accepted write to an idle engine moves into the shift register one cycle later. `tx_empty_o` returns to 1 in that same cycle, and the transfer starts.
- R4: `len_code_i` selects the character length: a value of 1 to 7 gives that many bits, and 0 gives 8 bits. Byte bits 7 down to 8-N are sent on `sdo_o`, most significant first.
- R5: The N received bits appear on `rd_data_o[N-1:0]`, with the last bit received in bit 0 and the upper bits zero. The value holds until the next character completes.
- R6: `rx_full_o` is a pulse that lasts one clock cycle. It occurs exactly once per completed character, in the same cycle that `rd_data_o` updates.
- R7: In master mode, `sck_o` idles low. Each bit takes 4 clock cycles: 2 with `sck_o` low, then 2 with it high. `sdi_i` is sampled at the edge where `sck_o` rises, and `sdo_o` changes only while `sck_o` is low.
- R8: In slave mode, while `ss_n_i`=0, the block samples `sdi_i` on each rising `sck_i` and shifts `sdo_o` on each falling `sck_i`. A write does not produce any clock.
- R9: A command write sets `ssv_o` from data bit 0 and `eof_o` from data bit 1. The bus write (`cmd_wr_i`) and the DMA write (`dma_cmd_wr_i`) use the same encoding. When both occur in the same cycle, the bus write wins.
- R10: When a master character finishes with `eof_o`=1, `ssv_o` is set to 1 and `eof_o` is cleared. With `eof_o`=0, `ssv_o` is left unchanged.
- R11: `ss_n_o` follows `ssv_o` in master mode and is held at 1 in slave mode. In slave mode, `sck_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode |
| len_code_i | input | 3 | Character length code (0 means 8) |
| data_wr_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 8 | Transmit character, left-justified |
| rd_data_o | output | 8 | Received character, right-justified |
| tx_empty_o | output | 1 | Holding register can accept a write |
| rx_full_o | output | 1 | One-cycle pulse when a character is received |
| cmd_wr_i | input | 1 | Bus write strobe for the command register |
| cmd_wdata_i | input | 2 | Bus command value: bit 1 is end-of-frame, bit 0 is select level |
| dma_cmd_wr_i | input | 1 | DMA write strobe for the command register |
| dma_cmd_i | input | 2 | DMA command value, same encoding as the bus |
| ssv_o | output | 1 | Current select-level bit |
| eof_o | output | 1 | Current end-of-frame bit |
| sck_i | input | 1 | Serial clock from the outside master (slave mode) |
| ss_n_i | input | 1 | Select input from the outside master (slave mode) |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Generated serial clock (master mode) |
| sdo_o | output | 1 | Serial data out |
| ss_n_o | output | 1 | Select output pin |

## Verification
The bench runs lengths 1, 4 and 8, and random lengths, in both directions. An engine that justified the characters the wrong way, or counted one bit too many or too few, would show wrong bits on the wire and a shifted `rd_data_o`. A write made while a second character is already waiting checks the drop rule: a design that took that write would send the wrong second character. The bench also covers the automatic release of the select line and a bus write colliding with a DMA write. A wrong priority, or a release that ignored the marker, would leave `ssv_o` at the wrong level. Slave transfers use an outside clock to check that a write alone produces no clock and that data moves only on `sck_i` edges.

// File: rtl/spi_dp_pkg.sv
// Package: shared helpers for the serial data path.
// Assumes character lengths are encoded in a field as wide as log2 of the byte width.
package spi_dp_pkg;

    // Effective bit count of a length code; code 0 stands for the full width.
    function automatic int unsigned eff_len(input int unsigned code, input int unsigned full_w);
        return (code == 0) ? full_w : code;
    endfunction

endpackage

// File: rtl/spi_dp_txhold.sv
// Transmit holding register with its empty flag.
// Takes a bus write only when empty; goes empty again when the engine takes the data.
module spi_dp_txhold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] hold_o,
    output logic              empty_o
);

    logic accept;
    assign accept = wr_i && empty_o;

    // Capture accepted writes and track the empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o  <= '0;
            empty_o <= 1'b1;
        end else if (accept) begin
            hold_o  <= wdata_i;
            empty_o <= 1'b0;
        end else if (take_i) begin
            empty_o <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_dp_cmd.sv
// Command register: select level and end-of-frame marker.
// Priority from highest: bus write, DMA write, automatic release at frame end.
module spi_dp_cmd (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr_i,
    input  logic [1:0] bus_data_i,
    input  logic       dma_wr_i,
    input  logic [1:0] dma_data_i,
    input  logic       char_done_i,
    output logic       ssv_o,
    output logic       eof_o
);

    // Update the two command bits by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssv_o <= 1'b1;
            eof_o <= 1'b0;
        end else if (bus_wr_i) begin
            ssv_o <= bus_data_i[0];
            eof_o <= bus_data_i[1];
        end else if (dma_wr_i) begin
            ssv_o <= dma_data_i[0];
            eof_o <= dma_data_i[1];
        end else if (char_done_i && eof_o) begin
            ssv_o <= 1'b1;
            eof_o <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_dp_engine.sv
// Shift engine for master and slave operation.
// Master: generates the serial clock at clk/4 (low 2, high 2), samples on the rising edge,
// shifts on the falling edge. Slave: sck_i and ss_n_i are assumed synchronous to clk,
// with each level held for at least 2 cycles.
module spi_dp_engine
    import spi_dp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic [CNT_W-1:0]  len_code_i,
    input  logic              tx_pend_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              load_o,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              sdi_i,
    output logic              sck_o,
    output logic              sdo_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              char_done_o
);

    logic              active, mid, sck_prev;
    logic [1:0]        phase;
    logic [CNT_W-1:0]  bit_cnt, last_idx;
    logic [DATA_W-1:0] shreg, rx_sh, rx_base, rx_next;
    logic              last_bit, m_rise, m_fall, s_rise, s_fall, rise;

    // Decode the length code into the index of the final bit.
    always_comb begin
        last_idx = CNT_W'(eff_len(int'(len_code_i), DATA_W) - 1);
        last_bit = (bit_cnt == last_idx);
    end

    // Find the sample and shift edges for each mode.
    always_comb begin
        m_rise = master_i && active && (phase == 2'd1);
        m_fall = master_i && active && (phase == 2'd3);
        s_rise = !master_i && !ss_n_i && sck_i && !sck_prev;
        s_fall = !master_i && !ss_n_i && !sck_i && sck_prev && mid;
        rise   = m_rise || s_rise;
        load_o = tx_pend_i && (master_i ? !active : !mid);
    end

    // Build the next receive word; the first bit of a character clears the old content.
    always_comb begin
        rx_base = (bit_cnt == '0) ? '0 : rx_sh;
        rx_next = {rx_base[DATA_W-2:0], sdi_i};
    end

    // Sequence the shift register, the bit counter and the receive capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            mid       <= 1'b0;
            sck_prev  <= 1'b0;
            phase     <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            rx_sh     <= '0;
            rx_data_o <= '0;
            rx_full_o <= 1'b0;
        end else begin
            rx_full_o <= 1'b0;
            sck_prev  <= sck_i;
            if (load_o) shreg <= tx_data_i;
            if (rise) begin
                rx_sh <= rx_next;
                if (last_bit) begin
                    rx_data_o <= rx_next;
                    rx_full_o <= 1'b1;
                end
            end
            if (master_i) begin
                mid <= 1'b0;
                if (load_o) begin
                    active  <= 1'b1;
                    phase   <= '0;
                    bit_cnt <= '0;
                end else if (active) begin
                    phase <= phase + 2'd1;
                    if (m_fall) begin
                        if (last_bit) begin
                            active  <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            shreg   <= shreg << 1;
                        end
                    end
                end
            end else begin
                active <= 1'b0;
                phase  <= '0;
                if (ss_n_i) begin
                    mid     <= 1'b0;
                    bit_cnt <= '0;
                end else begin
                    if (s_rise) mid <= 1'b1;
                    if (s_fall) begin
                        if (last_bit) begin
                            mid     <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            shreg   <= shreg << 1;
                        end
                    end
                end
            end
        end
    end

    assign sck_o       = master_i && active && phase[1];
    assign sdo_o       = shreg[DATA_W-1];
    assign char_done_o = m_fall && last_bit;

endmodule

// File: rtl/spi_datapath.sv
// Top of the variable-length serial data path.
// Joins the holding register, the shift engine and the command register.
// The select pin is an output only in master mode.
module spi_datapath #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic [CNT_W-1:0]  len_code_i,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] data_wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              tx_empty_o,
    output logic              rx_full_o,
    input  logic              cmd_wr_i,
    input  logic [1:0]        cmd_wdata_i,
    input  logic              dma_cmd_wr_i,
    input  logic [1:0]        dma_cmd_i,
    output logic              ssv_o,
    output logic              eof_o,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              sdi_i,
    output logic              sck_o,
    output logic              sdo_o,
    output logic              ss_n_o
);

    logic [DATA_W-1:0] hold;
    logic              load, char_done;

    spi_dp_txhold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (data_wr_i),
        .wdata_i (data_wdata_i),
        .take_i  (load),
        .hold_o  (hold),
        .empty_o (tx_empty_o)
    );

    spi_dp_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_i    (master_i),
        .len_code_i  (len_code_i),
        .tx_pend_i   (!tx_empty_o),
        .tx_data_i   (hold),
        .load_o      (load),
        .sck_i       (sck_i),
        .ss_n_i      (ss_n_i),
        .sdi_i       (sdi_i),
        .sck_o       (sck_o),
        .sdo_o       (sdo_o),
        .rx_data_o   (rd_data_o),
        .rx_full_o   (rx_full_o),
        .char_done_o (char_done)
    );

    spi_dp_cmd u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (cmd_wr_i),
        .bus_data_i  (cmd_wdata_i),
        .dma_wr_i    (dma_cmd_wr_i),
        .dma_data_i  (dma_cmd_i),
        .char_done_i (char_done),
        .ssv_o       (ssv_o),
        .eof_o       (eof_o)
    );

    assign ss_n_o = master_i ? ssv_o : 1'b1;

endmodule

// File: rtl/spi_datapath_chk.sv
// Port-level properties of the serial data path, bound to every instance of the top.
module spi_datapath_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_i,
    input logic              data_wr_i,
    input logic              tx_empty_o,
    input logic              rx_full_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              sck_o,
    input logic              sdo_o,
    input logic              cmd_wr_i,
    input logic [1:0]        cmd_wdata_i,
    input logic              dma_cmd_wr_i,
    input logic [1:0]        dma_cmd_i,
    input logic              ssv_o,
    input logic              eof_o
);

    a_r2_accept_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && tx_empty_o) |=> !tx_empty_o);

    a_r6_full_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_o |=> !rx_full_o);

    a_r5_rdata_moves_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(rd_data_o) |-> rx_full_o);

    a_r7_sck_high_two: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && $rose(sck_o)) |=> sck_o);

    a_r7_sck_falls_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && sck_o && $past(sck_o)) |=> !sck_o);

    a_r7_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(sdo_o));

    a_r9_bus_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_i |=> ({eof_o, ssv_o} == $past(cmd_wdata_i)));

    a_r9_dma_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cmd_wr_i && !cmd_wr_i) |=> ({eof_o, ssv_o} == $past(dma_cmd_i)));

endmodule

bind spi_datapath spi_datapath_chk #(.DATA_W(DATA_W)) u_spi_datapath_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_i     (master_i),
    .data_wr_i    (data_wr_i),
    .tx_empty_o   (tx_empty_o),
    .rx_full_o    (rx_full_o),
    .rd_data_o    (rd_data_o),
    .sck_o        (sck_o),
    .sdo_o        (sdo_o),
    .cmd_wr_i     (cmd_wr_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .dma_cmd_wr_i (dma_cmd_wr_i),
    .dma_cmd_i    (dma_cmd_i),
    .ssv_o        (ssv_o),
    .eof_o        (eof_o)
);

// File: tb/test_spi_datapath.sv
module test_spi_datapath;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_i = 1'b1;
    logic [2:0] len_code_i = 3'd0;
    logic       data_wr_i = 1'b0;
    logic [7:0] data_wdata_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       tx_empty_o, rx_full_o;
    logic       cmd_wr_i = 1'b0;
    logic [1:0] cmd_wdata_i = 2'b00;
    logic       dma_cmd_wr_i = 1'b0;
    logic [1:0] dma_cmd_i = 2'b00;
    logic       ssv_o, eof_o;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       sdi_slv = 1'b0;
    logic       sck_o, sdo_o, ss_n_o;
    logic       sdi_i;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [15:0] pat16 = '0;
    logic [15:0] cap = '0;
    int          capn = 0;
    int          rxf_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_datapath i_spi_datapath (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .len_code_i(len_code_i),
        .data_wr_i(data_wr_i), .data_wdata_i(data_wdata_i), .rd_data_o(rd_data_o),
        .tx_empty_o(tx_empty_o), .rx_full_o(rx_full_o), .cmd_wr_i(cmd_wr_i),
        .cmd_wdata_i(cmd_wdata_i), .dma_cmd_wr_i(dma_cmd_wr_i), .dma_cmd_i(dma_cmd_i),
        .ssv_o(ssv_o), .eof_o(eof_o), .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi_i(sdi_i),
        .sck_o(sck_o), .sdo_o(sdo_o), .ss_n_o(ss_n_o)
    );

    // Model of an outside slave device: it presents pat16[15], shifts on the falling edge
    // and captures sdo_o on the rising edge.
    assign sdi_i = master_i ? pat16[15] : sdi_slv;
    always @(negedge sck_o) pat16 = pat16 << 1;
    always @(posedge sck_o) begin
        cap  = {cap[14:0], sdo_o};
        capn = capn + 1;
    end
    always @(posedge clk) if (rst_n && rx_full_o) rxf_cnt = rxf_cnt + 1;

    function automatic int nbits(input logic [2:0] code);
        return (code == 3'd0) ? 8 : int'(code);
    endfunction

    // Left-justified transmit byte -> the bits expected on the wire, right-aligned.
    function automatic logic [7:0] tx_expect(input logic [7:0] d, input logic [2:0] code);
        return d >> (8 - nbits(code));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] d);
        data_wdata_i = d;
        data_wr_i    = 1'b1;
        @(negedge clk);
        data_wr_i    = 1'b0;
    endtask

    task automatic cmd_write(input logic [1:0] v);
        cmd_wdata_i = v;
        cmd_wr_i    = 1'b1;
        @(negedge clk);
        cmd_wr_i    = 1'b0;
    endtask

    // One master character with a given outside-slave pattern.
    task automatic master_xfer(input logic [7:0] d, input logic [2:0] code, input logic [7:0] p,
                               input string tag);
        int n;
        n = nbits(code);
        len_code_i = code;
        pat16 = {p, 8'h00};
        cap = '0; capn = 0; rxf_cnt = 0;
        bus_write(d);
        check({tag, " R2 empty clears"}, tx_empty_o, 1'b0);
        @(negedge clk);
        check({tag, " R3 empty sets at load"}, tx_empty_o, 1'b1);
        wait_cyc(4 * n + 3);
        check({tag, " R4 bit count"}, capn, n);
        check({tag, " R4 bits on wire"}, cap[7:0] & 8'((1 << n) - 1), tx_expect(d, code));
        check({tag, " R5 received"}, rd_data_o, p >> (8 - n));
        check({tag, " R6 one full pulse"}, rxf_cnt, 1);
        check({tag, " R7 sck idle low"}, sck_o, 1'b0);
    endtask

    // One slave character, clocked by the bench as the outside master.
    task automatic slave_xfer(input logic [7:0] d, input logic [2:0] code, input logic [7:0] p,
                              input string tag);
        int n;
        logic [7:0] got;
        n = nbits(code);
        len_code_i = code;
        got = '0; rxf_cnt = 0; capn = 0;
        bus_write(d);
        wait_cyc(3);
        check({tag, " R8 write makes no clock"}, capn, 0);
        check({tag, " R3 slave load sets empty"}, tx_empty_o, 1'b1);
        ss_n_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            sdi_slv = p[7-k];
            wait_cyc(3);
            got = {got[6:0], sdo_o};
            sck_i = 1'b1;
            wait_cyc(3);
            sck_i = 1'b0;
        end
        wait_cyc(3);
        ss_n_i = 1'b1;
        wait_cyc(2);
        check({tag, " R8 slave bits out"}, got, tx_expect(d, code));
        check({tag, " R5 slave received"}, rd_data_o, p >> (8 - n));
        check({tag, " R6 slave one pulse"}, rxf_cnt, 1);
        check({tag, " R11 sck_o quiet"}, sck_o, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        wait_cyc(3);
        // R1: reset values
        check("R1 tx_empty", tx_empty_o, 1'b1);
        check("R1 rx_full", rx_full_o, 1'b0);
        check("R1 rd_data", rd_data_o, 8'h00);
        check("R1 ssv/eof", {eof_o, ssv_o}, 2'b01);
        check("R1 sck", sck_o, 1'b0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R4/R5: directed lengths
        master_xfer(8'hA5, 3'd0, 8'h3C, "len8");
        master_xfer(8'hB0, 3'd4, 8'h90, "len4");
        master_xfer(8'h80, 3'd1, 8'h80, "len1");
        master_xfer(8'h7F, 3'd7, 8'hFE, "len7");

        // R2: a write while a character waits is dropped
        len_code_i = 3'd0;
        pat16 = 16'h1234; cap = '0; capn = 0; rxf_cnt = 0;
        bus_write(8'hC3);
        @(negedge clk);
        bus_write(8'h5A);
        check("R2 second write holds", tx_empty_o, 1'b0);
        bus_write(8'hFF);
        wait_cyc(70);
        check("R2 two characters only", capn, 16);
        check("R2 dropped write absent", cap, 16'hC35A);
        check("R6 two pulses", rxf_cnt, 2);
        check("R5 last received", rd_data_o, 8'h34);

        // R9/R10/R11: command register
        cmd_write(2'b10);
        check("R9 bus write", {eof_o, ssv_o}, 2'b10);
        check("R11 pin follows ssv", ss_n_o, 1'b0);
        master_xfer(8'h66, 3'd0, 8'h11, "eof");
        check("R10 release after frame", {eof_o, ssv_o}, 2'b01);
        cmd_write(2'b00);
        master_xfer(8'h99, 3'd3, 8'h40, "noeof");
        check("R10 held without marker", {eof_o, ssv_o}, 2'b00);
        dma_cmd_i = 2'b11; dma_cmd_wr_i = 1'b1;
        @(negedge clk);
        dma_cmd_wr_i = 1'b0;
        check("R9 dma write", {eof_o, ssv_o}, 2'b11);
        dma_cmd_i = 2'b11; dma_cmd_wr_i = 1'b1;
        cmd_wdata_i = 2'b00; cmd_wr_i = 1'b1;
        @(negedge clk);
        dma_cmd_wr_i = 1'b0; cmd_wr_i = 1'b0;
        check("R9 bus beats dma", {eof_o, ssv_o}, 2'b00);

        // R7/R4/R5: random master traffic
        for (int t = 0; t < 24; t++) begin
            master_xfer(8'($urandom), 3'($urandom), 8'($urandom), "rand");
        end

        // R8/R11: slave mode
        master_i = 1'b0;
        @(negedge clk);
        check("R11 slave pin high", ss_n_o, 1'b1);
        slave_xfer(8'hC3, 3'd0, 8'hA6, "slv8");
        slave_xfer(8'hD8, 3'd5, 8'h68, "slv5");
        for (int t = 0; t < 6; t++) begin
            slave_xfer(8'($urandom), 3'($urandom), 8'($urandom), "slvrand");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule